// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block is a one-channel direct-memory-access engine controlled through a small register port. Software loads a word-aligned memory address and a word count, and picks a direction and whether completion should interrupt. The engine then moves the block between memory and a device without the processor touching each word. Each word is moved in one granted cycle on a memory master port that uses a request/grant handshake.

Bus mastership is requested for one word at a time and released after it. The processor therefore gets the bus between words. When the last word has moved, the engine sets a completion flag. If interrupts are enabled, it also raises an interrupt line, and a read of the control register clears that line.

Top module: `dma_channel`

## Requirements
- R1: After reset, the address, count and control registers all read as zero, and `mem_req`, `irq` and `dev_out_valid` are 0.
- R2: Register select 0 is the current address, 1 the remaining word count, 2 the control register. In the control register, bit 31 is the interrupt flag, bit 30 the interrupt enable, bit 1 the direction and bit 0 the completion flag. Address, enable and direction read back as written.
- R3: A write of a nonzero count while idle starts a transfer: `mem_req` is 1 in the cycle right after the write edge.
- R4: Each cycle with `mem_req` and `mem_gnt` both high moves exactly one word. On the next edge the address grows by DATA_W/8 and the count drops by one. While the grant is withheld, the address is held.
- R5: After every granted cycle, `mem_req` is low for at least the following cycle.
- R6: With direction 1 (memory to device), `mem_we` is 0. The word read at each granted cycle appears on `dev_out_data` with `dev_out_valid` high in the next cycle, in address order.
- R7: With direction 0 (device to memory), `mem_we` is 1 and `mem_wdata` equals `dev_in_data`. `dev_in_ack` is high exactly in each granted cycle.
- R8: When the count reaches zero, the completion flag is set and requests stop. The interrupt flag is set only if the enable bit is 1.
- R9: The `irq` output follows the interrupt flag. A read of the control register returns the flag and clears it on that edge.
- R10: Any count write made while idle clears the completion flag. A count of zero starts nothing.
- R11: While a transfer is in progress, writes to the address, the count and the direction bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt flag on control read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Bus request for one word |
| mem_gnt | input | 1 | Bus grant; word moves when high with request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_we | output | 1 | 1 = memory write |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| dev_in_data | input | DATA_W | Word offered by the device |
| dev_in_ack | output | 1 | Device word taken |
| dev_out_valid | output | 1 | Word for the device is valid |
| dev_out_data | output | DATA_W | Word for the device |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach is a register write that lands while a transfer is still running, because the attempt only means something if the engine is demonstrably busy at that edge. The stimulus issues the writes right after the start, while each word still needs two cycles. The final address and count then show the block that was originally programmed. The device-to-memory run throttles the grant so that requests sit waiting for several cycles, which exercises the held address. The interrupt is cleared through the control register read, checked in the read cycle and in the cycle after it.

// File: rtl/dma_channel_pkg.sv
package dma_channel_pkg;
   localparam int REG_W = 32;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;

   localparam int CTL_IRQ  = 31;
   localparam int CTL_IE   = 30;
   localparam int CTL_DIR  = 1;
   localparam int CTL_DONE = 0;
endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
   import dma_channel_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              beat,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cnt,
   output logic              active,
   output logic              dir,
   output logic              ie,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STEP);

   logic done_q;
   logic last_beat;
   logic ctrl_read;

   assign active    = (cnt != '0);
   assign last_beat = beat && (cnt == CNT_W'(1));
   assign ctrl_read = reg_rd && (reg_sel == SEL_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cnt      <= '0;
         dir      <= 1'b0;
         ie       <= 1'b0;
         irq      <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         if (beat) begin
            cur_addr <= cur_addr + ADDR_INC;
            cnt      <= cnt - CNT_W'(1);
         end
         if (last_beat) begin
            done_q <= 1'b1;
         end
         if (last_beat && ie) begin
            irq <= 1'b1;
         end else if (ctrl_read) begin
            irq <= 1'b0;
         end
         if (reg_wr && !active) begin
            case (reg_sel)
               SEL_ADDR:  cur_addr <= reg_wdata[ADDR_W-1:0];
               SEL_COUNT: begin
                  cnt    <= reg_wdata[CNT_W-1:0];
                  done_q <= 1'b0;
               end
               SEL_CTRL:  dir <= reg_wdata[CTL_DIR];
               default:   ;
            endcase
         end
         if (reg_wr && (reg_sel == SEL_CTRL)) begin
            ie <= reg_wdata[CTL_IE];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_ADDR:  reg_rdata[ADDR_W-1:0] = cur_addr;
         SEL_COUNT: reg_rdata[CNT_W-1:0]  = cnt;
         SEL_CTRL: begin
            reg_rdata[CTL_IRQ]  = irq;
            reg_rdata[CTL_IE]   = ie;
            reg_rdata[CTL_DIR]  = dir;
            reg_rdata[CTL_DONE] = done_q;
         end
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq #(
   parameter int IDLE_GAP = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic mem_gnt,
   output logic mem_req,
   output logic beat
);
   localparam int GAP_W = $clog2(IDLE_GAP + 1);

   logic [GAP_W-1:0] gap_cnt;

   assign mem_req = active && (gap_cnt == '0);
   assign beat    = mem_req && mem_gnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_cnt <= '0;
      end else if (beat) begin
         gap_cnt <= GAP_W'(IDLE_GAP);
      end else if (gap_cnt != '0) begin
         gap_cnt <= gap_cnt - GAP_W'(1);
      end
   end
endmodule

// File: rtl/dma_ch_path.sv
module dma_ch_path #(
   parameter int DATA_W      = 32,
   parameter bit DEV_OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic              dir,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] dev_in_data,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              dev_in_ack,
   output logic              dev_out_valid,
   output logic [DATA_W-1:0] dev_out_data
);
   assign mem_we     = !dir;
   assign mem_wdata  = dev_in_data;
   assign dev_in_ack = beat && !dir;

   generate
      if (DEV_OUT_REG) begin : g_out_flop
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dev_out_valid <= 1'b0;
               dev_out_data  <= '0;
            end else begin
               dev_out_valid <= beat && dir;
               if (beat && dir) begin
                  dev_out_data <= mem_rdata;
               end
            end
         end
      end else begin : g_out_direct
         assign dev_out_valid = beat && dir;
         assign dev_out_data  = mem_rdata;
      end
   endgenerate
endmodule

// File: rtl/dma_channel.sv
module dma_channel
   import dma_channel_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 16,
   parameter int IDLE_GAP    = 1,
   parameter bit DEV_OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] dev_in_data,
   output logic              dev_in_ack,
   output logic              dev_out_valid,
   output logic [DATA_W-1:0] dev_out_data,
   output logic              irq
);
   localparam int STEP = DATA_W / 8;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
         $error("DATA_W must be a nonzero multiple of 8");
      end
      if (ADDR_W < 4 || ADDR_W > REG_W) begin : g_bad_addr_w
         $error("ADDR_W must lie between 4 and the register width");
      end
      if (CNT_W < 1 || CNT_W > 30) begin : g_bad_cnt_w
         $error("CNT_W must lie between 1 and 30");
      end
      if (IDLE_GAP < 1) begin : g_bad_gap
         $error("IDLE_GAP must be at least 1");
      end
   endgenerate

   logic              beat;
   logic              active;
   logic              dir;
   logic              ie;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] cur_addr;

   assign mem_addr = cur_addr;

   dma_ch_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .STEP   (STEP)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .beat      (beat),
      .cur_addr  (cur_addr),
      .cnt       (cnt),
      .active    (active),
      .dir       (dir),
      .ie        (ie),
      .irq       (irq)
   );

   dma_ch_seq #(
      .IDLE_GAP (IDLE_GAP)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .mem_gnt (mem_gnt),
      .mem_req (mem_req),
      .beat    (beat)
   );

   dma_ch_path #(
      .DATA_W      (DATA_W),
      .DEV_OUT_REG (DEV_OUT_REG)
   ) u_path (
      .clk           (clk),
      .rst_n         (rst_n),
      .beat          (beat),
      .dir           (dir),
      .mem_rdata     (mem_rdata),
      .dev_in_data   (dev_in_data),
      .mem_we        (mem_we),
      .mem_wdata     (mem_wdata),
      .dev_in_ack    (dev_in_ack),
      .dev_out_valid (dev_out_valid),
      .dev_out_data  (dev_out_data)
   );
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk
   import dma_channel_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int STEP   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic              dir,
   input logic              ie,
   input logic [CNT_W-1:0]  cnt,
   input logic              irq,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [1:0]        reg_sel
);
   logic granted;
   assign granted = mem_req && mem_gnt;

   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      granted |=> !mem_req); // R5
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> $stable(mem_addr)); // R4
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      granted |=> (mem_addr == $past(mem_addr) + ADDR_W'(STEP))); // R4
   AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      granted |=> (cnt == $past(cnt) - CNT_W'(1))); // R4
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> !mem_req); // R8
   AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(ie) && $past(cnt) == CNT_W'(1))); // R8
   AST_IRQ_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_sel == SEL_CTRL && !(granted && cnt == CNT_W'(1))) |=> !irq); // R9
   AST_BUSY_CNT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && reg_wr && reg_sel == SEL_COUNT && !granted) |=> $stable(cnt)); // R11
   AST_WE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_we == !dir)); // R6
endmodule

bind dma_channel dma_channel_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .STEP   (STEP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_req  (mem_req),
   .mem_gnt  (mem_gnt),
   .mem_addr (mem_addr),
   .mem_we   (mem_we),
   .dir      (dir),
   .ie       (ie),
   .cnt      (cnt),
   .irq      (irq),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_sel  (reg_sel)
);

// File: tb/dma_channel_bench.sv
`timescale 1ns/100ps
module dma_channel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_gnt, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [31:0] dev_in_data, dev_out_data;
   logic        dev_in_ack, dev_out_valid, irq;

   always #2.5 clk = ~clk;

   dma_channel u_dma_channel (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .dev_in_data(dev_in_data), .dev_in_ack(dev_in_ack), .dev_out_valid(dev_out_valid),
      .dev_out_data(dev_out_data), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int gnt_mode = 0;
   logic gnt_allow = 1'b1;
   logic prev_beat = 1'b0;
   logic [31:0] dev_word;
   logic [31:0] exp_out_q[$];
   logic [31:0] exp_raddr_q[$];
   logic [63:0] exp_wr_q[$];

   function automatic logic [31:0] mem_model(input logic [31:0] a);
      return {a[15:0], ~a[15:0]};
   endfunction

   assign mem_rdata   = mem_model(mem_addr);
   assign mem_gnt     = mem_req & gnt_allow;
   assign dev_in_data = dev_word;

   always @(posedge clk) begin
      if (!rst_n) dev_word <= 32'hC0DE0000;
      else if (dev_in_ack) dev_word <= dev_word + 32'd1;
      gnt_allow <= (gnt_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard items as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (prev_beat) chk(!mem_req, "R5 request released after word", 64'(mem_req), 64'd0);
         prev_beat = mem_req && mem_gnt;
         if (mem_req && mem_gnt) begin
            if (mem_we) begin
               if (exp_wr_q.size() == 0) chk(1'b0, "R7 unexpected memory write", {mem_addr, mem_wdata}, 64'd0);
               else begin
                  logic [63:0] e;
                  e = exp_wr_q.pop_front();
                  chk({mem_addr, mem_wdata} == e, "R7 memory write addr/data", {mem_addr, mem_wdata}, e);
               end
               chk(dev_in_ack, "R7 device ack on granted cycle", 64'(dev_in_ack), 64'd1);
            end else begin
               if (exp_raddr_q.size() == 0) chk(1'b0, "R4 unexpected memory read", 64'(mem_addr), 64'd0);
               else begin
                  logic [31:0] ea;
                  ea = exp_raddr_q.pop_front();
                  chk(mem_addr == ea, "R4 read address step", 64'(mem_addr), 64'(ea));
               end
            end
         end
         if (dev_out_valid) begin
            if (exp_out_q.size() == 0) chk(1'b0, "R6 unexpected device word", 64'(dev_out_data), 64'd0);
            else begin
               logic [31:0] ed;
               ed = exp_out_q.pop_front();
               chk(dev_out_data == ed, "R6 device word", 64'(dev_out_data), 64'(ed));
            end
         end
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [31:0] data);
      @(negedge clk);
      reg_sel = sel; reg_rd = 1'b1;
      #1 data = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic wait_idle();
      logic [31:0] c;
      for (int i = 0; i < 200; i++) begin
         reg_read(2'd1, c);
         if (c == 0) break;
      end
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      reg_read(2'd0, v); chk(v == 0, "R1 address after reset", 64'(v), 64'd0);
      reg_read(2'd1, v); chk(v == 0, "R1 count after reset", 64'(v), 64'd0);
      reg_read(2'd2, v); chk(v == 0, "R1 control after reset", 64'(v), 64'd0);
      chk(!mem_req && !irq && !dev_out_valid, "R1 outputs idle", {mem_req, irq, dev_out_valid}, 64'd0);

      // R2 register readback
      reg_write(2'd0, 32'h0000_0100);
      reg_write(2'd2, 32'h4000_0002);
      reg_read(2'd0, v); chk(v == 32'h100, "R2 address readback", 64'(v), 64'h100);
      reg_read(2'd2, v); chk(v == 32'h4000_0002, "R2 control readback", 64'(v), 64'h4000_0002);

      // memory to device, 4 words, grant always
      for (int k = 0; k < 4; k++) begin
         exp_raddr_q.push_back(32'h100 + 32'(4 * k));
         exp_out_q.push_back(mem_model(32'h100 + 32'(4 * k)));
      end
      reg_write(2'd1, 32'd4);
      #1 chk(mem_req, "R3 request after count write", 64'(mem_req), 64'd1);
      // R11 writes while busy
      reg_write(2'd0, 32'h0000_0999);
      reg_write(2'd1, 32'd9);
      reg_write(2'd2, 32'h4000_0000);
      for (int i = 0; i < 100 && !irq; i++) @(negedge clk);
      chk(irq, "R8 interrupt raised at completion", 64'(irq), 64'd1);
      reg_read(2'd0, v); chk(v == 32'h110, "R11 address after busy write", 64'(v), 64'h110);
      reg_read(2'd1, v); chk(v == 0, "R11 count after busy write", 64'(v), 64'd0);
      reg_read(2'd2, v); chk(v == 32'hC000_0003, "R9 control shows flag and done", 64'(v), 64'hC000_0003);
      #1 chk(!irq, "R9 irq cleared by control read", 64'(irq), 64'd0);
      reg_read(2'd2, v); chk(v == 32'h4000_0003, "R9 flag clear in register", 64'(v), 64'h4000_0003);
      chk(exp_out_q.size() == 0 && exp_raddr_q.size() == 0, "R6 all device words delivered",
          64'(exp_out_q.size()), 64'd0);

      // device to memory, 3 words, throttled grant, no interrupt
      gnt_mode = 1;
      reg_write(2'd2, 32'h0000_0000);
      reg_write(2'd0, 32'h0000_0200);
      for (int k = 0; k < 3; k++)
         exp_wr_q.push_back({32'h200 + 32'(4 * k), 32'hC0DE0000 + 32'(k)});
      reg_write(2'd1, 32'd3);
      reg_read(2'd2, v); chk(v == 0, "R10 count write clears done", 64'(v), 64'd0);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(!irq, "R8 no interrupt with enable clear", 64'(irq), 64'd0);
      reg_read(2'd2, v); chk(v == 32'h0000_0001, "R8 done without flag", 64'(v), 64'h1);
      reg_read(2'd0, v); chk(v == 32'h20C, "R4 final address", 64'(v), 64'h20C);
      chk(exp_wr_q.size() == 0, "R7 all memory writes seen", 64'(exp_wr_q.size()), 64'd0);

      // R10 zero count
      reg_write(2'd1, 32'd0);
      #1 chk(!mem_req, "R10 zero count starts nothing", 64'(mem_req), 64'd0);
      reg_read(2'd2, v); chk(v == 0, "R10 zero count clears done", 64'(v), 64'd0);
      repeat (3) @(negedge clk);
      chk(!mem_req, "R10 still idle", 64'(mem_req), 64'd0);

      summary();
      $finish;
   end
endmodule